// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Read Controller

This block runs read cycles on an external memory whose address and data travel over one shared 16-bit pin set. The clock ticks once per phase, and four phases (Q1 to Q4) form one bus cycle. A single-clock request from the core carries an address. The controller then drives that address onto the pins and raises an address latch strobe so external logic can catch it. Next it lets go of the pins and pulls the active-low output enable down for two phases. It samples the returned word on the edge where output enable rises, and hands the word back to the core with a one-clock valid pulse.

The sequencer is a five-state machine. The states are IDLE, PH_ADDR (Q1), PH_HOLD (Q2), PH_RD_A (Q3) and PH_RD_B (Q4). The transitions are as follows. IDLE goes to PH_ADDR when a request is accepted. Each phase state moves on to the next one unconditionally. PH_RD_B always returns to IDLE. The pins are modelled as a separate drive value, drive enable and input, so the bus direction is visible at the ports. The write strobe is held inactive.

Top module: `mbr_reader`

## Requirements
- R1: After reset, ale=0, oe_n=1, wr_n=1, ad_oe=0, busy=0 and rdata_valid=0.
- R2: When req=1 while busy=0, the next phase is Q1. In Q1, ale=1, ad_oe=1, ad_out equals the requested address and busy=1.
- R3: In Q2, ale=0, ad_oe=1 with the same address still on ad_out, and oe_n=1.
- R4: In Q3 and Q4, ad_oe=0 and oe_n=0. ad_oe and a low oe_n are never seen together.
- R5: ale stays high for exactly one phase and oe_n stays low for exactly two phases. A new ale pulse cannot begin within four phases of the previous one.
- R6: ad_in is captured on the clock edge that ends Q4, which is the edge where oe_n returns high. In the phase after Q4, rdata_valid=1 for exactly one clock, with rdata equal to the captured word.
- R7: wr_n is 1 in every phase.
- R8: A req raised while busy=1 is ignored. It starts no ale pulse and does not change the address or the data of the cycle in progress.
- R9: A req accepted in the phase where rdata_valid is high starts the next cycle at once, so its Q1 follows immediately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock, one edge per quarter cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Read request from the core |
| addr | input | 16 | Address for the read |
| busy | output | 1 | High while a bus cycle is in progress |
| rdata | output | 16 | Captured read data |
| rdata_valid | output | 1 | One-clock pulse marking rdata |
| ad_out | output | 16 | Value driven onto the shared pins |
| ad_oe | output | 1 | Pin drive enable |
| ad_in | input | 16 | Value seen on the shared pins |
| ale | output | 1 | Address latch enable, active high |
| oe_n | output | 1 | Output enable, active low |
| wr_n | output | 1 | Write strobe, held high |

## Verification
Some properties hold on every cycle, and the in-line assertions check those. The pins are never driven while output enable is low. The strobe widths and the spacing between ale pulses are checked, along with the valid pulse that follows each rise of output enable and the constant write strobe. The bench memory model is needed to show the rest. It checks that the word captured is the one returned for the latched address. It checks that a request made mid-cycle leaves both the address and the data alone, and that back-to-back cycles carry the right addresses.

// File: rtl/mbr_pkg.sv
package mbr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_PH_ADDR = 3'd1,
        ST_PH_HOLD = 3'd2,
        ST_PH_RD_A = 3'd3,
        ST_PH_RD_B = 3'd4
    } phase_t;
endpackage

// File: rtl/mbr_phase_fsm.sv
module mbr_phase_fsm
    import mbr_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   req,
    output logic   accept,
    output phase_t state
);
    phase_t state_nx;

    assign accept = req && (state == ST_IDLE);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (accept) state_nx = ST_PH_ADDR;
            ST_PH_ADDR: state_nx = ST_PH_HOLD;
            ST_PH_HOLD: state_nx = ST_PH_RD_A;
            ST_PH_RD_A: state_nx = ST_PH_RD_B;
            ST_PH_RD_B: state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // R8: a new cycle only leaves IDLE
    p_start_from_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PH_ADDR) |-> ($past(state) == ST_IDLE));
endmodule

// File: rtl/mbr_addr_path.sv
module mbr_addr_path #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] addr,
    output logic [W-1:0] addr_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    addr_q <= '0;
        else if (load) addr_q <= addr;
    end
endmodule

// File: rtl/mbr_capture.sv
module mbr_capture #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         strobe,
    input  logic [W-1:0] ad_in,
    output logic [W-1:0] rdata,
    output logic         rdata_valid
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata       <= '0;
            rdata_valid <= 1'b0;
        end else begin
            rdata_valid <= strobe;
            if (strobe) rdata <= ad_in;
        end
    end

    // R6: valid is a single-clock pulse
    p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_valid |=> !rdata_valid);
endmodule

// File: rtl/mbr_reader.sv
module mbr_reader
    import mbr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req,
    input  logic [W-1:0] addr,
    output logic         busy,
    output logic [W-1:0] rdata,
    output logic         rdata_valid,
    output logic [W-1:0] ad_out,
    output logic         ad_oe,
    input  logic [W-1:0] ad_in,
    output logic         ale,
    output logic         oe_n,
    output logic         wr_n
);
    phase_t       state;
    logic         accept;
    logic [W-1:0] addr_q;

    mbr_phase_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .req(req), .accept(accept), .state(state)
    );

    mbr_addr_path #(.W(W)) u_addr (
        .clk(clk), .rst_n(rst_n), .load(accept), .addr(addr), .addr_q(addr_q)
    );

    mbr_capture #(.W(W)) u_cap (
        .clk(clk), .rst_n(rst_n), .strobe(state == ST_PH_RD_B),
        .ad_in(ad_in), .rdata(rdata), .rdata_valid(rdata_valid)
    );

    always_comb begin
        ale    = 1'b0;
        ad_oe  = 1'b0;
        oe_n   = 1'b1;
        wr_n   = 1'b1;
        busy   = 1'b1;
        ad_out = addr_q;
        unique case (state)
            ST_IDLE:    busy = 1'b0;
            ST_PH_ADDR: begin ale = 1'b1; ad_oe = 1'b1; end
            ST_PH_HOLD: ad_oe = 1'b1;
            ST_PH_RD_A: oe_n = 1'b0;
            ST_PH_RD_B: oe_n = 1'b0;
            default:    busy = 1'b0;
        endcase
    end

    p_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !busy) |=> (ale && ad_oe && busy && ad_out == $past(addr)));
    p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ale) |-> (ad_oe && oe_n && $stable(ad_out)));
    p_no_contention_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(ad_oe && !oe_n));
    p_ale_spacing_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale ##1 !ale ##1 !ale);
    p_oe_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oe_n) |=> !oe_n ##1 oe_n);
    p_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe_n) |-> (rdata_valid && rdata == $past(ad_in)));
    p_write_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_n);
endmodule

// File: tb/test_mbr_reader.sv
module test_mbr_reader;
    localparam int W = 16;
    localparam time TCLK = 10;
    localparam int NV = 5;
    // {address, word the memory model returns for it}
    localparam logic [31:0] VEC [NV] = '{
        {16'h0000, 16'h3C5A},
        {16'hFFFF, 16'hC3A5},
        {16'h1234, 16'h0848},
        {16'hA5C3, 16'hFFFF},
        {16'h8001, 16'h3DDA}
    };

    logic clk = 0, rst_n = 0, req = 0;
    logic [W-1:0] addr = '0;
    logic busy, rdata_valid, ad_oe, ale, oe_n, wr_n;
    logic [W-1:0] rdata, ad_out, ad_in, lat;
    int n_chk = 0, n_fail = 0, cyc = 0;
    bit clash = 0, done = 0;

    always #(TCLK/2) clk = ~clk;

    mbr_reader #(.W(W)) i_mbr_reader (
        .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .busy(busy),
        .rdata(rdata), .rdata_valid(rdata_valid), .ad_out(ad_out), .ad_oe(ad_oe),
        .ad_in(ad_in), .ale(ale), .oe_n(oe_n), .wr_n(wr_n)
    );

    // memory model: latch address while ale high, return swapped^key when enabled
    always @(posedge clk) if (ale) lat <= ad_out;
    assign ad_in = !oe_n ? ({lat[7:0], lat[15:8]} ^ 16'h3C5A) : 16'hBEEF;
    always @(negedge clk) begin
        if (rst_n && ad_oe && !oe_n) clash = 1;
        cyc++;
    end

    task automatic chk(input string r, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // issue req during one clock, then check Q1..valid phases at negedges
    task automatic run_cycle(input logic [W-1:0] a, input logic [W-1:0] d, input bit poke);
        @(negedge clk); req = 1; addr = a;
        @(negedge clk); req = 0; addr = ~a;
        chk("R2 ale", ale, 1); chk("R2 ad_oe", ad_oe, 1);
        chk("R2 ad_out", ad_out, a); chk("R2 busy", busy, 1);
        if (poke) begin req = 1; addr = 16'h5555; end
        @(negedge clk); req = 0;
        chk("R3 ale", ale, 0); chk("R3 ad_oe", ad_oe, 1);
        chk("R3 ad_out", ad_out, a); chk("R3 oe_n", oe_n, 1);
        @(negedge clk);
        chk("R4 Q3 ad_oe", ad_oe, 0); chk("R4 Q3 oe_n", oe_n, 0);
        @(negedge clk);
        chk("R4 Q4 ad_oe", ad_oe, 0); chk("R4 Q4 oe_n", oe_n, 0);
        chk("R5 Q4 ale", ale, 0); chk("R7 wr_n", wr_n, 1);
        @(negedge clk);
        chk("R6 valid", rdata_valid, 1); chk("R6 rdata", rdata, d);
        chk("R5 oe_n back high", oe_n, 1);
    endtask

    initial begin
        #(TCLK * 3);
        chk("R1 ale", ale, 0); chk("R1 oe_n", oe_n, 1); chk("R1 wr_n", wr_n, 1);
        chk("R1 ad_oe", ad_oe, 0); chk("R1 busy", busy, 0); chk("R1 valid", rdata_valid, 0);
        @(negedge clk); rst_n = 1;
        for (int i = 0; i < NV; i++) begin
            run_cycle(VEC[i][31:16], VEC[i][15:0], 0);
            @(negedge clk);
            chk("R6 valid drops", rdata_valid, 0);
            chk("R6 rdata held", rdata, VEC[i][15:0]);
        end
        // R8: request mid-cycle must be ignored
        run_cycle(16'h1234, 16'h0848, 1);
        @(negedge clk);
        chk("R8 no second ale", ale, 0); chk("R8 idle", busy, 0);
        chk("R8 rdata kept", rdata, 16'h0848);
        // R9: back-to-back, req in the valid phase
        run_cycle(16'hFFFF, 16'hC3A5, 0);
        req = 1; addr = 16'h8001;
        @(negedge clk); req = 0;
        chk("R9 immediate ale", ale, 1); chk("R9 address", ad_out, 16'h8001);
        repeat (4) @(negedge clk);
        chk("R9 valid", rdata_valid, 1); chk("R9 rdata", rdata, 16'h3DDA);
        chk("R4 no contention", clash, 0);
        finish_up();
    end

    initial begin
        wait (cyc > 5000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_up();
    end
endmodule